// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands. It repeatedly subtracts one value from the other and swaps the two values when needed. A small datapath holds two working registers, X and Y. A hardwired four-state controller drives that datapath with five control lines: load X, load Y, input select, swap and subtract. The controller receives two conditions from the datapath. One says that X is zero. The other says that a swap is needed.

A parameter chooses how the controller state is stored. It is either a two-flip-flop binary code or a four-flip-flop one-hot code, and the behaviour at the ports is the same in both cases. To use the block, place two operands on the inputs and pulse `start` while the engine is idle. Then wait for the one-cycle `done` pulse and read `result`.

Top module: `gcd_sub_engine`

## Requirements
- R1: While `rst_n` is low, and after its release, `done` is 0, `result` is 0 and the controller is idle. Asserting reset during a computation aborts it.
- R2: The controller has four states: idle, test, swap and finish. With `ONE_HOT=0` they are coded 00, 01, 10 and 11 in two flip-flops. With `ONE_HOT=1` they are coded 0001, 0010, 0100 and 1000 in four flip-flops. Exactly one state term is active in every cycle, and both encodings give identical `done`/`result` sequences for the same inputs.
- R3: If `start` is high in a cycle spent idle, `a_in` is loaded into X and `b_in` into Y at that clock edge. `start` has no effect while a computation is in progress.
- R4: In each cycle in the test state, the engine does exactly one of three things. If X is zero, it moves to finish. Otherwise, if X < Y or Y is zero, it moves to the swap state, exchanges X and Y there, and returns to test. Otherwise it replaces X with X − Y and stays in test. A swap and a subtraction never occur in the same cycle.
- R5: `result` (register Y) equals gcd(a, b) when `done` is high. If one operand is zero, the result is the other operand, and if both are zero, the result is 0.
- R6: `done` is high for exactly one cycle, in the cycle after the engine enters the finish state from a test cycle that sees X = 0. Counting the start edge as edge 1, `done` appears after edge k, where k = 1 + (number of subtract steps) + 2·(number of swaps) + 1.
- R7: After `done`, `result` keeps its value through any number of idle cycles, whatever `a_in` and `b_in` do, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (sampled only when idle) |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| result | output | W | Greatest common divisor (register Y) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The result is due a data-dependent number of cycles after `start`. That number is k from R6: one cycle per subtraction, two per swap, one for the final zero test and one to reach the finish state. For each operand pair, the bench computes k with its own step model and computes the expected divisor with a modulo-based Euclid function. It then samples on falling edges, one per cycle after the start edge. It requires `done` to stay low before edge k, be high exactly at k and be low at k+1. One-hot and binary instances run in lockstep on the same stimulus and are compared at the finish cycle.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  // State indices; the binary code of a state equals its index
  localparam int NUM_ST   = 4;
  localparam int ST_IDLE  = 0;
  localparam int ST_TEST  = 1;
  localparam int ST_SWAP  = 2;
  localparam int ST_FIN   = 3;
  localparam int ST_BITS  = $clog2(NUM_ST);
endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              x_zero,
  input  logic              need_swap,
  output logic [NUM_ST-1:0] st_term,
  output logic              ld_x,
  output logic              ld_y,
  output logic              sel_in,
  output logic              swap_en,
  output logic              sub_en
);
  // Per-state next-condition terms, shared by both encodings
  logic go_test, stay_idle, to_swap, to_fin, keep_sub;

  assign stay_idle = st_term[ST_IDLE] & ~start;
  assign go_test   = st_term[ST_IDLE] & start;
  assign to_fin    = st_term[ST_TEST] & x_zero;
  assign to_swap   = st_term[ST_TEST] & ~x_zero & need_swap;
  assign keep_sub  = st_term[ST_TEST] & ~x_zero & ~need_swap;

  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_ST-1:0] oh_q, oh_d;
      logic              legal;
      assign legal = (oh_q != '0) && ((oh_q & (oh_q - 1'b1)) == '0);
      always_comb begin
        oh_d = '0;
        if (!legal) begin
          oh_d[ST_IDLE] = 1'b1;
        end else begin
          oh_d[ST_IDLE] = stay_idle | st_term[ST_FIN];
          oh_d[ST_TEST] = go_test | keep_sub | st_term[ST_SWAP];
          oh_d[ST_SWAP] = to_swap;
          oh_d[ST_FIN]  = to_fin;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oh_q <= NUM_ST'(1) << ST_IDLE;
        else        oh_q <= oh_d;
      end
      assign st_term = legal ? oh_q : '0;
    end else begin : g_binary
      logic [ST_BITS-1:0] bn_q, bn_d;
      always_comb begin
        bn_d = bn_q;
        if (stay_idle | st_term[ST_FIN]) bn_d = ST_BITS'(ST_IDLE);
        if (go_test | keep_sub | st_term[ST_SWAP]) bn_d = ST_BITS'(ST_TEST);
        if (to_swap) bn_d = ST_BITS'(ST_SWAP);
        if (to_fin)  bn_d = ST_BITS'(ST_FIN);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bn_q <= ST_BITS'(ST_IDLE);
        else        bn_q <= bn_d;
      end
      assign st_term = NUM_ST'(1) << bn_q;
    end
  endgenerate

  // Output equations: OR of the state terms in which each line is active
  assign sel_in  = go_test;
  assign ld_x    = go_test | keep_sub | st_term[ST_SWAP];
  assign ld_y    = go_test | st_term[ST_SWAP];
  assign swap_en = st_term[ST_SWAP];
  assign sub_en  = keep_sub;
endmodule

// File: rtl/gcd_dp.sv
module gcd_dp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ld_x,
  input  logic         ld_y,
  input  logic         sel_in,
  input  logic         swap_en,
  input  logic         sub_en,
  output logic [W-1:0] xr,
  output logic [W-1:0] yr,
  output logic         x_zero,
  output logic         need_swap
);
  function automatic logic [W-1:0] f_diff(input logic [W-1:0] x, input logic [W-1:0] y);
    return x - y;
  endfunction

  function automatic logic f_swap_cond(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x < y) || (y == '0);
  endfunction

  logic [W-1:0] x_nxt, y_nxt;

  always_comb begin
    if (sel_in)       x_nxt = a_in;
    else if (swap_en) x_nxt = yr;
    else if (sub_en)  x_nxt = f_diff(xr, yr);
    else              x_nxt = xr;
    if (sel_in)       y_nxt = b_in;
    else if (swap_en) y_nxt = xr;
    else              y_nxt = yr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr <= '0;
      yr <= '0;
    end else begin
      if (ld_x) xr <= x_nxt;
      if (ld_y) yr <= y_nxt;
    end
  end

  assign x_zero    = (xr == '0);
  assign need_swap = f_swap_cond(xr, yr);
endmodule

// File: rtl/gcd_sub_engine.sv
module gcd_sub_engine
  import gcd_pkg::*;
#(
  parameter int W       = 8,
  parameter bit ONE_HOT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         done
);
  logic [NUM_ST-1:0] st_term;
  logic ld_x, ld_y, sel_in, swap_en, sub_en, x_zero, need_swap;
  logic [W-1:0] xr, yr;

  gcd_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_zero(x_zero), .need_swap(need_swap),
    .st_term(st_term), .ld_x(ld_x), .ld_y(ld_y),
    .sel_in(sel_in), .swap_en(swap_en), .sub_en(sub_en)
  );

  gcd_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ld_x(ld_x), .ld_y(ld_y), .sel_in(sel_in),
    .swap_en(swap_en), .sub_en(sub_en),
    .xr(xr), .yr(yr), .x_zero(x_zero), .need_swap(need_swap)
  );

  assign result = yr;
  assign done   = st_term[ST_FIN];
endmodule

// File: rtl/gcd_sub_chk.sv
module gcd_sub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] result,
  input logic [W-1:0] xr,
  input logic [W-1:0] yr,
  input logic [3:0]   st_term,
  input logic         swap_en,
  input logic         sub_en
);
  assert_one_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_term) == 1);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_term[0] && start) |=> (xr == $past(a_in) && yr == $past(b_in)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_term[0] && !start) |=> st_term[0]);

  assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> (xr == $past(yr) && yr == $past(xr)));

  assert_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |=> (xr == $past(xr) - $past(yr) && $stable(yr)));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_en && sub_en));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_term[0] && !start) |=> $stable(result));
endmodule

bind gcd_sub_engine gcd_sub_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .a_in(a_in), .b_in(b_in), .result(result), .xr(xr), .yr(yr),
  .st_term(st_term), .swap_en(swap_en), .sub_en(sub_en)
);

// File: tb/gcd_sub_engine_tb.sv
module gcd_sub_engine_tb;
  localparam int W  = 8;
  localparam int NV = 12;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {8'd48, 8'd18}, {8'd18, 8'd48}, {8'd7, 8'd7},    {8'd0, 8'd9},
    {8'd12, 8'd0},  {8'd0, 8'd0},   {8'd255, 8'd1},  {8'd17, 8'd13},
    {8'd100, 8'd75},{8'd128, 8'd96},{8'd1, 8'd255},  {8'd81, 8'd27}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] res_oh, res_bin;
  logic done_oh, done_bin;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gcd_sub_engine #(.W(W), .ONE_HOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .result(res_oh), .done(done_oh));
  gcd_sub_engine #(.W(W), .ONE_HOT(1'b0)) u_bin (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .result(res_bin), .done(done_bin));

  function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p = a, q = b, t;
    while (q != 0) begin t = p % q; p = q; q = t; end
    return p;
  endfunction

  // Cycle at which done is due, counting the start edge as 1 (R6)
  function automatic int due_cycle(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x = a, y = b, t;
    int k = 1;
    forever begin
      if (x == 0) return k + 1;
      if (x < y || y == 0) begin t = x; x = y; y = t; k += 2; end
      else begin x = x - y; k += 1; end
    end
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b);
    int k, cnt;
    bit early;
    logic [W-1:0] g;
    k = due_cycle(a, b);
    g = ref_gcd(a, b);
    @(negedge clk); a_in = a; b_in = b; start = 1;
    @(negedge clk); start = 0; cnt = 1; early = 0;
    while (cnt < k) begin
      if (done_oh || done_bin) early = 1;
      @(negedge clk); cnt++;
    end
    check(!early && done_oh, "R4 R6 done timing", int'(done_oh), 1);
    check(res_oh == g, "R5 gcd value", int'(res_oh), int'(g));
    check(res_bin == res_oh && done_bin == done_oh, "R2 encodings agree",
          int'(res_bin), int'(res_oh));
    a_in = ~a; b_in = ~b;
    @(negedge clk);
    check(!done_oh && !done_bin, "R6 single pulse", int'(done_oh), 0);
    check(res_oh == g, "R7 result held", int'(res_oh), int'(g));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done_oh && res_oh == 0, "R1 in reset", int'(res_oh), 0);
    rst_n = 1;
    @(negedge clk);
    check(!done_oh && !done_bin && res_oh == 0 && res_bin == 0,
          "R1 after reset", int'(res_oh), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // R3: start while busy is ignored
    begin
      int k, cnt;
      bit early;
      k = due_cycle(8'd100, 8'd1);
      @(negedge clk); a_in = 8'd100; b_in = 8'd1; start = 1;
      @(negedge clk); start = 0; cnt = 1; early = 0;
      while (cnt < k) begin
        if (cnt == 4) begin a_in = 8'd9; b_in = 8'd6; start = 1; end
        else start = 0;
        if (done_oh) early = 1;
        @(negedge clk); cnt++;
      end
      start = 0;
      check(!early && done_oh && res_oh == 8'd1, "R3 busy start ignored",
            int'(res_oh), 1);
      @(negedge clk);
    end

    // R7: long idle with moving operands
    for (int i = 0; i < 6; i++) begin
      a_in = W'(i * 37); b_in = W'(i * 11);
      @(negedge clk);
    end
    check(res_oh == 8'd1 && res_bin == 8'd1, "R7 idle hold", int'(res_oh), 1);

    // R1: reset in mid computation aborts
    @(negedge clk); a_in = 8'd200; b_in = 8'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(!done_oh && res_oh == 0 && res_bin == 0, "R1 abort", int'(res_oh), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!done_oh && !done_bin, "R1 stays idle", int'(done_oh), 0);

    run_vec(8'd91, 8'd65);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule